// File: doc/BRIEF.md
# Deep Power-Down Sequencer

This block takes one core into a deep power-down state and brings it back out. In that state the core supply is pulled so low that the core counts as unpowered. When the power manager asks for sleep, the block runs the entry sequence:

1. Close the L2 cache.
2. Copy critical core state into a retention SRAM that stays on the always-on I/O supply.
3. Gate the clocks and switch the PLL off.
4. Ask the voltage regulator to drop the core rail.

A break event starts the exit sequence. The exit runs entirely in hardware, with no software involvement, and in this order:

1. Raise the rail.
2. Wait for the PLL to lock.
3. Ungate the clocks while an internal reset is held for a fixed number of cycles.
4. Restore the core state from the SRAM.
5. Reopen the L2 cache.

After the L2 cache is open, the block reports ready.

The regulator, the PLL and the SRAM appear only as level handshakes. Every wait on a handshake is bounded by a cycle-count timeout. A timeout sends the block to a terminal fault state. A break event that arrives during entry does not cut short a save in progress. The sequencer lets that save complete, skips the voltage drop and enters the exit path directly.

The states and their transitions are:

| State | Behaviour and transitions |
|---|---|
| `ST_RUN` | Reset state. Moves to `ST_L2_CLOSE` on a sleep request. |
| `ST_L2_CLOSE` | Lasts one cycle, then moves to `ST_SAVE`. |
| `ST_SAVE` | On save-done, moves to `ST_V_UP` if a break is pending, otherwise to `ST_CLK_OFF`. A timeout moves it to `ST_FAULT`. |
| `ST_CLK_OFF` | Lasts one cycle, then moves to `ST_V_DOWN`. |
| `ST_V_DOWN` | Moves to `ST_OFF` when power-good falls. A timeout moves it to `ST_FAULT`. |
| `ST_OFF` | Moves to `ST_V_UP` on a break event or a pending break. |
| `ST_V_UP` | Moves to `ST_PLL_WAIT` when power-good rises. A timeout moves it to `ST_FAULT`. |
| `ST_PLL_WAIT` | Moves to `ST_CORE_RST` on PLL lock. A timeout moves it to `ST_FAULT`. |
| `ST_CORE_RST` | Lasts `RST_CYCLES` cycles, then moves to `ST_RESTORE`. |
| `ST_RESTORE` | Moves to `ST_L2_OPEN` on restore-done. A timeout moves it to `ST_FAULT`. |
| `ST_L2_OPEN` | Lasts one cycle, then moves to `ST_RUN`. |
| `ST_FAULT` | Has no exit except reset. |

Top module: `dpd_sequencer`

## Requirements
- R1: After reset the block is in the run state. `ready`, `l2_en`, `clk_en` and `pll_en` are 1, and every other output is 0.
- R2: A sleep request sampled in the run state drops `l2_en` and `ready` at the next edge, with the clocks still on. One cycle later `save_req` goes to 1 and stays there until `save_done` is sampled.
- R3: When `save_done` is sampled with no break pending, all clocks, the PLL and every request go low for one cycle. `vr_down_req` is then held from the next cycle, through the wait for `vr_pgood` to fall, and for the whole power-off state.
- R4: A break event sampled in the power-off state raises `vr_up_req` at the next edge. Once `vr_pgood` is sampled high, `pll_en` alone is driven, and `clk_en` stays 0 until `pll_lock` is sampled high.
- R5: After lock, `clk_en` and `core_rst` are 1 together for exactly `RST_CYCLES` cycles. `core_rst` then drops and `restore_req` is held until `restore_done` is sampled.
- R6: After `restore_done`, `l2_en` is 1 for one cycle with `ready` still 0. `ready` goes to 1 on the following cycle and is never 1 without `l2_en`.
- R7: A break event during entry does not shorten the save: `save_req` stays 1 until `save_done`. The block then goes straight to `vr_up_req` without ever asserting `vr_down_req`, and then completes the normal exit.
- R8: If a handshake is not seen within `STEP_TIMEOUT` cycles of entering a wait state, `err` goes to 1 and every other output goes to 0. Neither sleep requests nor break events clear `err`; only reset does.
- R9: A break event sampled in the run state has no effect, and `ready` stays 1.
- R10: `vr_up_req` and `vr_down_req` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Power manager asks for deep power-down |
| break_evt | input | 1 | Wake event |
| vr_pgood | input | 1 | Regulator reports core rail at operating level |
| pll_lock | input | 1 | PLL reports lock |
| save_done | input | 1 | Retention SRAM finished storing state |
| restore_done | input | 1 | Retention SRAM finished restoring state |
| vr_down_req | output | 1 | Ask regulator to drop the core rail |
| vr_up_req | output | 1 | Ask regulator to raise the core rail |
| pll_en | output | 1 | PLL enable |
| clk_en | output | 1 | Core clock ungate |
| core_rst | output | 1 | Internal core reset |
| save_req | output | 1 | Start state save to retention SRAM |
| restore_req | output | 1 | Start state restore from retention SRAM |
| l2_en | output | 1 | L2 cache enable |
| ready | output | 1 | Core is awake and usable |
| err | output | 1 | Sticky step-timeout flag |

## Verification
Every output is decoded from the state register alone. An input sampled at one rising edge therefore shows on the outputs at that same edge: the first sample point after the stimulus. The reset hold lasts exactly `RST_CYCLES` cycles. A missing handshake raises the fault exactly `STEP_TIMEOUT` cycles after the wait state was entered. The driver drives inputs at falling edges and queues each expected output word with its absolute due cycle. The monitor samples a little after each rising edge, pops the entries that fall due and compares them. It also checks R10 on every cycle.

// File: rtl/dpd_pkg.sv
package dpd_pkg;

    typedef enum logic [3:0] {
        ST_RUN,
        ST_L2_CLOSE,
        ST_SAVE,
        ST_CLK_OFF,
        ST_V_DOWN,
        ST_OFF,
        ST_V_UP,
        ST_PLL_WAIT,
        ST_CORE_RST,
        ST_RESTORE,
        ST_L2_OPEN,
        ST_FAULT
    } dpd_state_e;

    typedef struct packed {
        logic ready;
        logic err;
        logic l2_en;
        logic clk_en;
        logic pll_en;
        logic core_rst;
        logic save_req;
        logic restore_req;
        logic vr_down_req;
        logic vr_up_req;
    } dpd_ctrl_t;

endpackage

// File: rtl/dpd_step_timer.sv
module dpd_step_timer #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic expired
);
    localparam int unsigned CW = $clog2(LIMIT) + 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    // counts cycles spent in the current state, saturating at the last one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q == LAST);

endmodule

// File: rtl/dpd_fsm.sv
module dpd_fsm
    import dpd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       break_evt,
    input  logic       vr_pgood,
    input  logic       pll_lock,
    input  logic       save_done,
    input  logic       restore_done,
    input  logic       wait_expired,
    input  logic       hold_done,
    output logic       restart,
    output dpd_ctrl_t  ctrl
);
    dpd_state_e state_q, state_d;
    logic       break_pend_q;
    logic       in_entry;
    logic       wake;

    assign in_entry = (state_q == ST_L2_CLOSE) || (state_q == ST_SAVE) ||
                      (state_q == ST_CLK_OFF)  || (state_q == ST_V_DOWN);
    assign wake     = break_evt || break_pend_q;

    // wake event remembered while entry is still running
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            break_pend_q <= 1'b0;
        end else if (state_q == ST_V_UP) begin
            break_pend_q <= 1'b0;
        end else if (in_entry && break_evt) begin
            break_pend_q <= 1'b1;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:      if (sleep_req) state_d = ST_L2_CLOSE;
            ST_L2_CLOSE: state_d = ST_SAVE;
            ST_SAVE: begin
                if (save_done)         state_d = wake ? ST_V_UP : ST_CLK_OFF;
                else if (wait_expired) state_d = ST_FAULT;
            end
            ST_CLK_OFF:  state_d = ST_V_DOWN;
            ST_V_DOWN: begin
                if (!vr_pgood)         state_d = ST_OFF;
                else if (wait_expired) state_d = ST_FAULT;
            end
            ST_OFF:      if (wake) state_d = ST_V_UP;
            ST_V_UP: begin
                if (vr_pgood)          state_d = ST_PLL_WAIT;
                else if (wait_expired) state_d = ST_FAULT;
            end
            ST_PLL_WAIT: begin
                if (pll_lock)          state_d = ST_CORE_RST;
                else if (wait_expired) state_d = ST_FAULT;
            end
            ST_CORE_RST: if (hold_done) state_d = ST_RESTORE;
            ST_RESTORE: begin
                if (restore_done)      state_d = ST_L2_OPEN;
                else if (wait_expired) state_d = ST_FAULT;
            end
            ST_L2_OPEN:  state_d = ST_RUN;
            ST_FAULT:    state_d = ST_FAULT;
            default:     state_d = ST_FAULT;
        endcase
    end

    assign restart = (state_d != state_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Moore output decode
    always_comb begin
        ctrl = '0;
        unique case (state_q)
            ST_RUN: begin
                ctrl.ready  = 1'b1;
                ctrl.l2_en  = 1'b1;
                ctrl.clk_en = 1'b1;
                ctrl.pll_en = 1'b1;
            end
            ST_L2_CLOSE: begin
                ctrl.clk_en = 1'b1;
                ctrl.pll_en = 1'b1;
            end
            ST_SAVE: begin
                ctrl.clk_en   = 1'b1;
                ctrl.pll_en   = 1'b1;
                ctrl.save_req = 1'b1;
            end
            ST_CLK_OFF: ;
            ST_V_DOWN:   ctrl.vr_down_req = 1'b1;
            ST_OFF:      ctrl.vr_down_req = 1'b1;
            ST_V_UP:     ctrl.vr_up_req   = 1'b1;
            ST_PLL_WAIT: ctrl.pll_en      = 1'b1;
            ST_CORE_RST: begin
                ctrl.pll_en   = 1'b1;
                ctrl.clk_en   = 1'b1;
                ctrl.core_rst = 1'b1;
            end
            ST_RESTORE: begin
                ctrl.pll_en      = 1'b1;
                ctrl.clk_en      = 1'b1;
                ctrl.restore_req = 1'b1;
            end
            ST_L2_OPEN: begin
                ctrl.pll_en = 1'b1;
                ctrl.clk_en = 1'b1;
                ctrl.l2_en  = 1'b1;
            end
            ST_FAULT:    ctrl.err = 1'b1;
            default:     ctrl.err = 1'b1;
        endcase
    end

    // rail requests are exclusive (R10)
    assert_vr_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl.vr_up_req && ctrl.vr_down_req));

    // clocks come back only after lock was seen (R4)
    assert_clk_after_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl.clk_en) |-> $past(pll_lock));

    // the rail drops two edges after the save completed (R3)
    assert_vdown_after_save_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl.vr_down_req) |-> $past(save_done, 2));

    // ready follows an open L2 (R6)
    assert_ready_after_l2_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl.ready) |-> $past(ctrl.l2_en));

    // fault is sticky (R8)
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.err |=> ctrl.err);

    // aborted entry never lowers the rail (R7)
    assert_abort_no_vdown_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAVE && save_done && wake) |=> (ctrl.vr_up_req && !ctrl.vr_down_req));

endmodule

// File: rtl/dpd_sequencer.sv
module dpd_sequencer #(
    parameter int unsigned STEP_TIMEOUT = 5000,
    parameter int unsigned RST_CYCLES   = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic break_evt,
    input  logic vr_pgood,
    input  logic pll_lock,
    input  logic save_done,
    input  logic restore_done,
    output logic vr_down_req,
    output logic vr_up_req,
    output logic pll_en,
    output logic clk_en,
    output logic core_rst,
    output logic save_req,
    output logic restore_req,
    output logic l2_en,
    output logic ready,
    output logic err
);
    import dpd_pkg::*;

    dpd_ctrl_t ctrl;
    logic      restart;
    logic      wait_expired;
    logic      hold_done;

    dpd_step_timer #(.LIMIT(STEP_TIMEOUT)) u_wait_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .expired (wait_expired)
    );

    dpd_step_timer #(.LIMIT(RST_CYCLES)) u_hold_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .expired (hold_done)
    );

    dpd_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sleep_req    (sleep_req),
        .break_evt    (break_evt),
        .vr_pgood     (vr_pgood),
        .pll_lock     (pll_lock),
        .save_done    (save_done),
        .restore_done (restore_done),
        .wait_expired (wait_expired),
        .hold_done    (hold_done),
        .restart      (restart),
        .ctrl         (ctrl)
    );

    assign vr_down_req = ctrl.vr_down_req;
    assign vr_up_req   = ctrl.vr_up_req;
    assign pll_en      = ctrl.pll_en;
    assign clk_en      = ctrl.clk_en;
    assign core_rst    = ctrl.core_rst;
    assign save_req    = ctrl.save_req;
    assign restore_req = ctrl.restore_req;
    assign l2_en       = ctrl.l2_en;
    assign ready       = ctrl.ready;
    assign err         = ctrl.err;

endmodule

// File: tb/dpd_sequencer_tb.sv
`timescale 1ns/1ps
module dpd_sequencer_tb;
    localparam int TO  = 20;
    localparam int RST = 4;

    // word: {ready,err,l2_en,clk_en,pll_en,core_rst,save_req,restore_req,vr_down_req,vr_up_req}
    localparam logic [9:0] V_RUN   = 10'b1_0_1_1_1_0_0_0_0_0;
    localparam logic [9:0] V_L2C   = 10'b0_0_0_1_1_0_0_0_0_0;
    localparam logic [9:0] V_SAVE  = 10'b0_0_0_1_1_0_1_0_0_0;
    localparam logic [9:0] V_COFF  = 10'b0_0_0_0_0_0_0_0_0_0;
    localparam logic [9:0] V_VDN   = 10'b0_0_0_0_0_0_0_0_1_0;
    localparam logic [9:0] V_VUP   = 10'b0_0_0_0_0_0_0_0_0_1;
    localparam logic [9:0] V_PLL   = 10'b0_0_0_0_1_0_0_0_0_0;
    localparam logic [9:0] V_RST   = 10'b0_0_0_1_1_1_0_0_0_0;
    localparam logic [9:0] V_REST  = 10'b0_0_0_1_1_0_0_1_0_0;
    localparam logic [9:0] V_L2ON  = 10'b0_0_1_1_1_0_0_0_0_0;
    localparam logic [9:0] V_FAULT = 10'b0_1_0_0_0_0_0_0_0_0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 1'b0, break_evt = 1'b0;
    logic vr_pgood = 1'b1, pll_lock = 1'b1;
    logic save_done = 1'b0, restore_done = 1'b0;
    logic vr_down_req, vr_up_req, pll_en, clk_en, core_rst;
    logic save_req, restore_req, l2_en, ready, err;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        int         due;
        logic [9:0] word;
        string      tag;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    dpd_sequencer #(.STEP_TIMEOUT(TO), .RST_CYCLES(RST)) u_dut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .break_evt(break_evt),
        .vr_pgood(vr_pgood), .pll_lock(pll_lock), .save_done(save_done),
        .restore_done(restore_done), .vr_down_req(vr_down_req), .vr_up_req(vr_up_req),
        .pll_en(pll_en), .clk_en(clk_en), .core_rst(core_rst), .save_req(save_req),
        .restore_req(restore_req), .l2_en(l2_en), .ready(ready), .err(err)
    );

    function automatic logic [9:0] outw();
        return {ready, err, l2_en, clk_en, pll_en, core_rst,
                save_req, restore_req, vr_down_req, vr_up_req};
    endfunction

    // driver side: queue an expected word d cycles from now, kept sorted by due cycle
    task automatic expect_in(int d, logic [9:0] w, string tag);
        exp_t e;
        int   pos;
        e.due = cyc + d; e.word = w; e.tag = tag;
        pos = q.size();
        for (int i = 0; i < q.size(); i++) begin
            if (q[i].due > e.due) begin pos = i; break; end
        end
        q.insert(pos, e);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: sample after each rising edge and pop due items
    always @(posedge clk) begin
        #2;
        cyc++;
        checks++;
        if (vr_up_req && vr_down_req) begin
            errors++;
            $display("FAIL R10 cycle %0d: up=%b down=%b expected not both", cyc, vr_up_req, vr_down_req);
        end
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (outw() !== e.word) begin
                errors++;
                $display("FAIL %s cycle %0d: actual %b expected %b", e.tag, cyc, outw(), e.word);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        // R1 reset state
        expect_in(1, V_RUN, "R1");
        expect_in(2, V_RUN, "R1");
        tick(3);

        // full entry then exit: R2..R6
        sleep_req = 1'b1;
        expect_in(1, V_L2C, "R2");
        tick(1);
        sleep_req = 1'b0;
        expect_in(1, V_SAVE, "R2");
        expect_in(3, V_SAVE, "R2");
        tick(3);
        save_done = 1'b1;
        expect_in(1, V_COFF, "R3");
        tick(1);
        save_done = 1'b0;
        pll_lock  = 1'b0;
        expect_in(1, V_VDN, "R3");
        expect_in(3, V_VDN, "R3");
        tick(3);
        vr_pgood = 1'b0;
        expect_in(1, V_VDN, "R3");
        expect_in(4, V_VDN, "R3");
        tick(4);
        break_evt = 1'b1;
        expect_in(1, V_VUP, "R4");
        tick(1);
        break_evt = 1'b0;
        expect_in(2, V_VUP, "R4");
        tick(2);
        vr_pgood = 1'b1;
        expect_in(1, V_PLL, "R4");
        expect_in(3, V_PLL, "R4");
        tick(3);
        pll_lock = 1'b1;
        for (int i = 1; i <= RST; i++) expect_in(i, V_RST, "R5");
        expect_in(RST + 1, V_REST, "R5");
        expect_in(RST + 2, V_REST, "R5");
        tick(RST + 2);
        restore_done = 1'b1;
        expect_in(1, V_L2ON, "R6");
        tick(1);
        restore_done = 1'b0;
        expect_in(1, V_RUN, "R6");
        tick(3);

        // R9: break in run state ignored
        break_evt = 1'b1;
        expect_in(1, V_RUN, "R9");
        tick(1);
        break_evt = 1'b0;
        expect_in(1, V_RUN, "R9");
        tick(2);

        // R7: break during save aborts entry after the save
        sleep_req = 1'b1;
        expect_in(1, V_L2C, "R7");
        tick(1);
        sleep_req = 1'b0;
        expect_in(1, V_SAVE, "R7");
        tick(1);
        break_evt = 1'b1;
        expect_in(1, V_SAVE, "R7");
        tick(1);
        break_evt = 1'b0;
        expect_in(1, V_SAVE, "R7");
        tick(2);
        save_done = 1'b1;
        expect_in(1, V_VUP, "R7");
        tick(1);
        save_done = 1'b0;
        expect_in(1, V_PLL, "R7");
        for (int i = 2; i <= RST + 1; i++) expect_in(i, V_RST, "R7");
        expect_in(RST + 2, V_REST, "R7");
        tick(RST + 3);
        restore_done = 1'b1;
        expect_in(1, V_L2ON, "R7");
        tick(1);
        restore_done = 1'b0;
        expect_in(1, V_RUN, "R7");
        tick(3);

        // R8: save handshake never arrives
        sleep_req = 1'b1;
        expect_in(1, V_L2C, "R8");
        tick(1);
        sleep_req = 1'b0;
        expect_in(TO, V_SAVE, "R8");
        expect_in(TO + 1, V_FAULT, "R8");
        tick(TO + 2);
        break_evt = 1'b1;
        sleep_req = 1'b1;
        expect_in(1, V_FAULT, "R8");
        expect_in(3, V_FAULT, "R8");
        tick(1);
        break_evt = 1'b0;
        sleep_req = 1'b0;
        tick(3);

        // reset clears the fault
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        expect_in(1, V_RUN, "R1");
        tick(3);

        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R1 pending expectations: actual %0d expected 0", q.size());
        end
        finish_run();
    end

endmodule